// File: doc/BRIEF.md
# Supply-Aware Three-State Mode Controller

This synchronous controller keeps the operating mode of an electronic control unit. It watches two digital input lines for any change of value and holds the most recent supply-voltage reading. That reading arrives as an already-converted unsigned code, marked by a valid strobe. The controller has three modes: initial, active and undervoltage.

After reset it sits in the initial mode. An input change moves it to active, but only while the supply is high enough. A low supply forces the undervoltage mode from any mode. The controller leaves undervoltage only above a separate, higher threshold, so a hysteresis band keeps it from toggling. On exit it returns to whichever mode it held before the supply sagged.

Each input is compared with its value one cycle earlier, with no further synchronization. The voltage code counts in steps of 10 mV, so 8 V, 9 V and 10 V are the codes 800, 900 and 1000. Every mode change also produces a one-cycle pulse.

Top module: `supply_mode_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `mode` is 2'b00 and `mode_changed` is 0.
- R2: `mode` uses only the codes 2'b00 (initial), 2'b01 (active) and 2'b10 (undervoltage). It never reads 2'b11.
- R3: A value change on `in_a` or `in_b` moves the controller from initial to active only if the latched voltage code is strictly above 1000. At exactly 1000 the mode stays initial.
- R4: Until the first strobed voltage sample has been latched, the mode stays initial whatever the inputs do.
- R5: A latched code strictly below 800 forces undervoltage from the initial mode and from the active mode. A code of exactly 800 does not.
- R6: Undervoltage is left only when the latched code is strictly above 900, and the controller then returns to the mode held before undervoltage. A code of exactly 900 keeps it in undervoltage.
- R7: An input change that falls in the same cycle as an undervoltage entry has no effect. After the exit the controller is back in the mode it had before, not in active.
- R8: `mode_changed` is 1 for exactly the one cycle in which `mode` shows a new value, and 0 otherwise.
- R9: A voltage code presented while `volt_valid` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_a | input | 1 | First digital input line |
| in_b | input | 1 | Second digital input line |
| volt_code | input | 12 | Supply voltage code, 10 mV per step |
| volt_valid | input | 1 | Strobe qualifying `volt_code` |
| mode | output | 2 | Current mode (00 initial, 01 active, 10 undervoltage) |
| mode_changed | output | 1 | One-cycle pulse when `mode` changes |

## Verification
An input change made before a clock edge shows up in `mode` and `mode_changed` right after that edge, so that result is due one edge later. A voltage sample first has to be latched, so its effect on the mode is due two edges after the strobe is presented.

The bench drives inputs on falling edges. It checks after one rising edge for input stimuli and after two for voltage stimuli. It then checks again one cycle later to confirm that the pulse has cleared. The threshold codes 799, 800, 900, 901, 1000 and 1001 are each applied on their own.

// File: rtl/supply_mode_ctrl.sv
module supply_mode_ctrl #(
  parameter int unsigned VW       = 12,
  parameter int unsigned UV_ENTER = 800,
  parameter int unsigned UV_EXIT  = 900,
  parameter int unsigned ACT_MIN  = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_a,
  input  logic          in_b,
  input  logic [VW-1:0] volt_code,
  input  logic          volt_valid,
  output logic [1:0]    mode,
  output logic          mode_changed
);
  localparam logic [1:0] M_INIT = 2'b00;
  localparam logic [1:0] M_ACT  = 2'b01;
  localparam logic [1:0] M_UV   = 2'b10;
  localparam logic [VW-1:0] TH_LO  = VW'(UV_ENTER);
  localparam logic [VW-1:0] TH_HI  = VW'(UV_EXIT);
  localparam logic [VW-1:0] TH_ACT = VW'(ACT_MIN);

  logic [1:0]    in_prev;
  logic [VW-1:0] v_q;
  logic          v_seen;
  logic [1:0]    mode_q, saved_q, mode_nx;
  logic          chg_q;

  wire any_edge = |({in_b, in_a} ^ in_prev);
  wire v_low    = v_seen && (v_q < TH_LO);
  wire v_exit   = v_seen && (v_q > TH_HI);
  wire v_act    = v_seen && (v_q > TH_ACT);

  always_comb begin
    mode_nx = mode_q;
    if (mode_q == M_UV) begin
      if (v_exit) mode_nx = saved_q;
    end else if (v_low) begin
      mode_nx = M_UV;
    end else if (mode_q == M_INIT && any_edge && v_act) begin
      mode_nx = M_ACT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_prev <= 2'b00;
      v_q     <= '0;
      v_seen  <= 1'b0;
      mode_q  <= M_INIT;
      saved_q <= M_INIT;
      chg_q   <= 1'b0;
    end else begin
      in_prev <= {in_b, in_a};
      if (volt_valid) begin
        v_q    <= volt_code;
        v_seen <= 1'b1;
      end
      if (mode_q != M_UV && mode_nx == M_UV) saved_q <= mode_q;
      mode_q <= mode_nx;
      chg_q  <= (mode_nx != mode_q);
    end
  end

  assign mode         = mode_q;
  assign mode_changed = chg_q;
endmodule

// File: rtl/supply_mode_ctrl_chk.sv
module supply_mode_ctrl_chk #(
  parameter int unsigned VW      = 12,
  parameter int unsigned UV_EXIT = 900,
  parameter int unsigned ACT_MIN = 1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          mode_changed,
  input logic          v_seen,
  input logic [VW-1:0] v_q
);
  assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  assert_pulse_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> mode_changed);

  assert_pulse_only_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_changed |-> (mode != $past(mode)));

  assert_hold_before_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !v_seen |=> (mode == 2'b00));

  assert_active_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b00 && mode == 2'b01) |-> ($past(v_q) > VW'(ACT_MIN)));

  assert_uv_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b10 && mode != 2'b10) |-> ($past(v_q) > VW'(UV_EXIT)));
endmodule

bind supply_mode_ctrl supply_mode_ctrl_chk #(
  .VW(VW), .UV_EXIT(UV_EXIT), .ACT_MIN(ACT_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode_q), .mode_changed(chg_q),
  .v_seen(v_seen), .v_q(v_q)
);

// File: tb/supply_mode_ctrl_bench.sv
module supply_mode_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_a = 1'b0, in_b = 1'b0;
  logic [11:0] volt_code = '0;
  logic        volt_valid = 1'b0;
  logic [1:0]  mode;
  logic        mode_changed;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  supply_mode_ctrl u_supply_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b),
    .volt_code(volt_code), .volt_valid(volt_valid),
    .mode(mode), .mode_changed(mode_changed)
  );

  task automatic chk(input string req, input logic [1:0] em, input logic ep);
    checks++;
    if (mode !== em || mode_changed !== ep) begin
      fails++;
      $display("FAIL %s: mode=%b pulse=%b expected mode=%b pulse=%b",
               req, mode, mode_changed, em, ep);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 in reset", 2'b00, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 2'b00, 1'b0);
  endtask

  task automatic toggle(input bit which_b);
    @(negedge clk);
    if (which_b) in_b = ~in_b; else in_a = ~in_a;
    @(negedge clk);
  endtask

  task automatic set_volt(input logic [11:0] c);
    @(negedge clk);
    volt_code = c; volt_valid = 1'b1;
    @(negedge clk);
    volt_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_no_sample();
    toggle(1'b0);
    chk("R4 change before sample", 2'b00, 1'b0);
    @(negedge clk) volt_code = 12'd1500;
    toggle(1'b1);
    chk("R9 unstrobed code ignored", 2'b00, 1'b0);
  endtask

  task automatic t_activate();
    set_volt(12'd1000);
    chk("R3 no move at 1000", 2'b00, 1'b0);
    toggle(1'b0);
    chk("R3 change at 1000 stays initial", 2'b00, 1'b0);
    set_volt(12'd1001);
    toggle(1'b1);
    chk("R3 change at 1001 activates", 2'b01, 1'b1);
    @(negedge clk);
    chk("R8 pulse lasts one cycle", 2'b01, 1'b0);
  endtask

  task automatic t_undervoltage();
    set_volt(12'd800);
    chk("R5 800 keeps active", 2'b01, 1'b0);
    set_volt(12'd799);
    chk("R5 799 forces undervoltage", 2'b10, 1'b1);
    @(negedge clk);
    chk("R8 pulse clears in undervoltage", 2'b10, 1'b0);
    set_volt(12'd900);
    chk("R6 900 keeps undervoltage", 2'b10, 1'b0);
    set_volt(12'd901);
    chk("R6 901 returns to active", 2'b01, 1'b1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    set_volt(12'd1200);
    chk("R4 sample alone keeps initial", 2'b00, 1'b0);
    @(negedge clk);
    volt_code = 12'd700; volt_valid = 1'b1;
    @(negedge clk);
    volt_valid = 1'b0;
    in_a = ~in_a;
    @(negedge clk);
    chk("R5 undervoltage from initial", 2'b10, 1'b1);
    set_volt(12'd1200);
    chk("R7 change ignored, back to initial", 2'b00, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    t_no_sample();
    t_activate();
    t_undervoltage();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule